// File: doc/BRIEF.md
# Composite Sync Timing Decoder

This block turns a sliced composite sync stream into four timing strobes for the rest of a video front end. The input is a single active-low sync bit. It is already digital, free of glitches and synchronous to the system clock. From it the block regenerates composite sync and finds the vertical interval of an interlaced 525/625-line stream. It then produces a vertical strobe, a back-porch gate after every sync pulse and a field-parity flag. All four outputs are active low: a value of 0 means asserted.

Every internal duration is a count of whole "units" times one programmable scale input, `scale_i`, given in clocks per unit. A unit is nominally one microsecond of a standard-rate line (64 units per line). Changing `scale_i` retargets the block to another clock frequency or another line rate without touching any other setting. The block measures the width of each low pulse to classify it as narrow (equalizing), line (horizontal sync) or broad (vertical). A vertical strobe starts on the rising edge of the first serration after a broad pulse. When the stream has no serrations, a timed default strobe starts instead. Field parity comes from the spacing between the last horizontal sync and the first equalizing pulse.

Top module: `csync_timing_decoder`

## Requirements
- R1: `csync_n_o` reproduces `csync_n_i` with a latency of two clock cycles: the value sampled at one rising edge appears on the output after the next rising edge.
- R2: When `csync_n_o` rises at the end of a low pulse at least BROAD_U·scale clocks wide, and no vertical strobe is active, `vsync_n_o` goes to 0 on that same clock.
- R3: When `csync_n_o` stays low with no vertical strobe active, `vsync_n_o` goes to 0 exactly DEF_U·scale clocks after the falling edge of `csync_n_o`.
- R4: `vsync_n_o` stays 0 for exactly VS_U·scale clocks. Further start conditions during that time neither extend nor restart it.
- R5: On every rising edge of `csync_n_o`, serrations included, `bporch_n_o` goes to 0 on the same clock and stays 0 for BP_U·scale clocks. A new rising edge reloads the full width.
- R6: A low pulse narrower than BROAD_U·scale clocks that ends before DEF_U·scale clocks has no effect on `vsync_n_o`.
- R7: A pulse narrower than NARROW_U·scale clocks that directly follows a line-width pulse (between NARROW_U·scale and BROAD_U·scale clocks) is the first equalizing pulse. If the spacing between the falling edges of the two pulses is at least 3/4 of LINE_U·scale clocks, the field is odd. At the next vertical strobe start, `odd_even_n_o` becomes 0. `odd_even_n_o` changes on no other clock.
- R8: If that spacing is shorter than 3/4 of a line, the field is even, and `odd_even_n_o` becomes 1 at the next vertical strobe start.
- R9: After reset all four outputs are 1.
- R10: Every duration above scales linearly with `scale_i`. At a different setting, the vertical and back-porch widths change in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csync_n_i | input | 1 | Sliced composite sync, 0 = sync tip |
| scale_i | input | SCALE_W | Clocks per timing unit |
| csync_n_o | output | 1 | Regenerated composite sync, active low |
| vsync_n_o | output | 1 | Vertical strobe, active low |
| bporch_n_o | output | 1 | Back-porch gate, active low |
| odd_even_n_o | output | 1 | Field flag, 0 = odd field, 1 = even field |

## Verification
The bench drives odd fields, even fields and fields whose broad interval has no serrations. Line widths and line spacing are randomised, and every output is compared on every clock against a cycle model written from the requirements. Some corner cases are probed directly:
- A pulse exactly one clock short of the broad threshold, and one exactly at it. A design with an off-by-one classifier would start a vertical strobe on the wrong one of these.
- The default-delay distance. A design that restarted its delay on serrations, or counted from the wrong edge, would land away from DEF_U·scale.
- The vertical width after a strobe that is still followed by broad pulses. A design that retriggers would stretch the pulse.
- The parity flag across odd and even fields. A wrong spacing rule would swap the flag.
- A change of `scale_i`. A design that hard-coded any duration would keep its old pulse widths.

// File: rtl/csd_pkg.sv
package csd_pkg;
  // Width class of one low pulse on the sync stream
  typedef enum logic [1:0] {
    PK_NARROW = 2'd0,
    PK_LINE   = 2'd1,
    PK_BROAD  = 2'd2
  } pulse_kind_e;
endpackage

// File: rtl/csd_input_stage.sv
module csd_input_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n_i,
  output logic level_o,
  output logic sync_n_o,
  output logic rise_o,
  output logic fall_o
);
  logic       s1_q, s1_d;
  logic       s2_q, s2_d;
  logic [1:0] warm_q, warm_d;

  always_comb begin
    s1_d   = sync_n_i;
    s2_d   = s1_q;
    warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      warm_q <= 2'd0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      warm_q <= warm_d;
    end
  end

  assign level_o  = s1_q;
  assign sync_n_o = s2_q;
  assign rise_o   = s1_q & ~s2_q;
  assign fall_o   = ~s1_q & s2_q;

  // R1
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (s2_q == $past(sync_n_i, 2)));
endmodule

// File: rtl/csd_pulse_meas.sv
module csd_pulse_meas
  import csd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] broad_thr_i,
  input  logic [CNT_W-1:0] narrow_thr_i,
  input  logic [CNT_W-1:0] full_gap_thr_i,
  output logic [CNT_W-1:0] low_cnt_o,
  output logic             broad_end_o,
  output logic             first_eq_o,
  output logic             gap_long_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_cnt_q, low_cnt_d;
  logic [CNT_W-1:0] gap_cnt_q, gap_cnt_d;
  logic [CNT_W-1:0] gap_lat_q, gap_lat_d;
  logic             prev_line_q, prev_line_d;
  pulse_kind_e      kind;

  always_comb begin
    if (low_cnt_q >= broad_thr_i)       kind = PK_BROAD;
    else if (low_cnt_q >= narrow_thr_i) kind = PK_LINE;
    else                                kind = PK_NARROW;
  end

  always_comb begin
    if (level_i)                  low_cnt_d = '0;
    else if (low_cnt_q == CNT_MAX) low_cnt_d = low_cnt_q;
    else                          low_cnt_d = low_cnt_q + 1'b1;

    if (fall_i)                   gap_cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (gap_cnt_q == CNT_MAX) gap_cnt_d = gap_cnt_q;
    else                          gap_cnt_d = gap_cnt_q + 1'b1;

    gap_lat_d   = fall_i ? gap_cnt_q : gap_lat_q;
    prev_line_d = rise_i ? (kind == PK_LINE) : prev_line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q   <= '0;
      gap_cnt_q   <= '0;
      gap_lat_q   <= '0;
      prev_line_q <= 1'b0;
    end else begin
      low_cnt_q   <= low_cnt_d;
      gap_cnt_q   <= gap_cnt_d;
      gap_lat_q   <= gap_lat_d;
      prev_line_q <= prev_line_d;
    end
  end

  assign low_cnt_o   = low_cnt_q;
  assign broad_end_o = rise_i && (kind == PK_BROAD);
  assign first_eq_o  = rise_i && (kind == PK_NARROW) && prev_line_q;
  assign gap_long_o  = (gap_lat_q >= full_gap_thr_i);

  // R6
  low_run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> (low_cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/csd_oneshot.sv
module csd_oneshot #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          RETRIG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;

  generate
    if (RETRIG) begin : g_retrig
      assign load = start_i;
    end else begin : g_once
      assign load = start_i && (cnt_q == '0);
    end
  endgenerate

  always_comb begin
    if (load)               cnt_d = len_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  // R5
  oneshot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (len_i != '0) && (RETRIG || !active_o)) |=> active_o);

  // R4
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!RETRIG && start_i && active_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/csd_field.sv
module csd_field (
  input  logic clk,
  input  logic rst_n,
  input  logic first_eq_i,
  input  logic gap_long_i,
  input  logic vs_start_i,
  output logic odd_even_n_o
);
  logic pend_odd_q, pend_odd_d;
  logic flag_q, flag_d;

  always_comb begin
    pend_odd_d = first_eq_i ? gap_long_i : pend_odd_q;
    flag_d     = vs_start_i ? ~pend_odd_q : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_odd_q <= 1'b0;
      flag_q     <= 1'b1;
    end else begin
      pend_odd_q <= pend_odd_d;
      flag_q     <= flag_d;
    end
  end

  assign odd_even_n_o = flag_q;

  // R7
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_start_i |=> $stable(flag_q));
endmodule

// File: rtl/csync_timing_decoder.sv
module csync_timing_decoder #(
  parameter int unsigned SCALE_W  = 8,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LINE_U   = 64,
  parameter int unsigned BROAD_U  = 16,
  parameter int unsigned NARROW_U = 3,
  parameter int unsigned DEF_U    = 55,
  parameter int unsigned VS_U     = 230,
  parameter int unsigned BP_U     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csync_n_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               csync_n_o,
  output logic               vsync_n_o,
  output logic               bporch_n_o,
  output logic               odd_even_n_o
);
  localparam int unsigned FULL_GAP_U = (LINE_U * 3) / 4;

  function automatic logic [CNT_W-1:0] scaled(input int unsigned units,
                                              input logic [SCALE_W-1:0] s);
    return CNT_W'(units * 32'(s));
  endfunction

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [CNT_W-1:0] broad_thr, narrow_thr, gap_thr, def_thr, vs_len, bp_len;
  always_comb begin
    broad_thr  = scaled(BROAD_U, scale_i);
    narrow_thr = scaled(NARROW_U, scale_i);
    gap_thr    = scaled(FULL_GAP_U, scale_i);
    def_thr    = scaled(DEF_U, scale_i);
    vs_len     = scaled(VS_U, scale_i);
    bp_len     = scaled(BP_U, scale_i);
  end

  logic level, rise, fall;
  logic [CNT_W-1:0] low_cnt;
  logic broad_end, first_eq, gap_long;
  logic vs_active, bp_active, vs_start, def_hit;

  csd_input_stage u_in (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sync_n_i (csync_n_i),
    .level_o  (level),
    .sync_n_o (csync_n_o),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  csd_pulse_meas #(.CNT_W(CNT_W)) u_meas (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .level_i        (level),
    .rise_i         (rise),
    .fall_i         (fall),
    .broad_thr_i    (broad_thr),
    .narrow_thr_i   (narrow_thr),
    .full_gap_thr_i (gap_thr),
    .low_cnt_o      (low_cnt),
    .broad_end_o    (broad_end),
    .first_eq_o     (first_eq),
    .gap_long_o     (gap_long)
  );

  always_comb begin
    def_hit  = !level && (def_thr != '0) && (low_cnt == def_thr);
    vs_start = !vs_active && (broad_end || def_hit);
  end

  csd_oneshot #(.CNT_W(CNT_W), .RETRIG(1'b0)) u_vs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (broad_end || def_hit),
    .len_i    (vs_len),
    .active_o (vs_active)
  );

  csd_oneshot #(.CNT_W(CNT_W), .RETRIG(1'b1)) u_bp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (rise),
    .len_i    (bp_len),
    .active_o (bp_active)
  );

  csd_field u_field (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .first_eq_i   (first_eq),
    .gap_long_i   (gap_long),
    .vs_start_i   (vs_start),
    .odd_even_n_o (odd_even_n_o)
  );

  assign vsync_n_o  = ~vs_active;
  assign bporch_n_o = ~bp_active;

  // R2
  serr_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (broad_end && vsync_n_o && (vs_len != '0)) |=> !vsync_n_o);

  // R3
  default_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (def_hit && vsync_n_o && (vs_len != '0)) |=> !vsync_n_o);

  // R5
  bp_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(csync_n_o) && (bp_len != '0)) |-> !bporch_n_o);

  // R6
  vs_fall_ctx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(vsync_n_o) |-> ($rose(csync_n_o) || !csync_n_o));
endmodule

// File: tb/sim_csync_timing_decoder.sv
module sim_csync_timing_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int LINE_U = 64, BROAD_U = 16, NARROW_U = 3, DEF_U = 55, VS_U = 230, BP_U = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n_i = 1'b1;
  logic [7:0] scale_i = 8'd2;
  logic csync_n_o, vsync_n_o, bporch_n_o, odd_even_n_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  csync_timing_decoder u0 (
    .clk(clk), .rst_n(rst_n), .csync_n_i(csync_n_i), .scale_i(scale_i),
    .csync_n_o(csync_n_o), .vsync_n_o(vsync_n_o), .bporch_n_o(bporch_n_o),
    .odd_even_n_o(odd_even_n_o)
  );

  int checks = 0, errors = 0, sc = 2;
  bit mon_en = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // input history for the reference model
  logic in_d1 = 1'b1, in_d2 = 1'b1;
  always @(posedge clk) begin
    in_d1 <= csync_n_i;
    in_d2 <= in_d1;
  end

  // reference model state
  int cyc = 0;
  bit m_cs = 1, m_oe = 1, m_pend = 0, m_pline = 0;
  int m_lw = 0, m_vsc = 0, m_bpc = 0, m_gap = 100000, m_lfall = -100000;
  // observations
  bit o_cs = 1, o_vs = 1, o_bp = 1;
  int vs_falls = 0, cs_fall_cyc = 0, vs_fall_cyc = 0, vs_width = 0;
  int bp_fall_cyc = 0, bp_width = 0, def_dist = 0;
  bit vs_on_rise = 0;

  always @(negedge clk) begin
    bit cs, rise, fall, start;
    int nlw;
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(1'b0, "watchdog", cyc, WATCHDOG);
      report();
    end
    if (mon_en) begin
      cs = in_d2;
      rise = cs && !m_cs;
      fall = !cs && m_cs;
      nlw = cs ? 0 : m_lw + 1;
      start = (m_vsc == 0) && ((rise && m_lw >= BROAD_U*sc) || (!cs && nlw == DEF_U*sc + 1));
      if (start) begin m_vsc = VS_U*sc; m_oe = !m_pend; end
      else if (m_vsc > 0) m_vsc--;
      if (rise) begin
        if (m_lw < NARROW_U*sc && m_pline) m_pend = (m_gap >= (LINE_U*3/4)*sc);
        m_pline = (m_lw >= NARROW_U*sc) && (m_lw < BROAD_U*sc);
        m_bpc = BP_U*sc;
      end else if (m_bpc > 0) m_bpc--;
      if (fall) begin m_gap = cyc - m_lfall; m_lfall = cyc; end
      m_lw = nlw;
      m_cs = cs;
      // per-cycle comparisons
      chk(csync_n_o == cs, "R1 csync", csync_n_o, cs);
      chk(vsync_n_o == (m_vsc == 0), "R4 vsync", vsync_n_o, m_vsc == 0);
      chk(bporch_n_o == (m_bpc == 0), "R5 bporch", bporch_n_o, m_bpc == 0);
      chk(odd_even_n_o == m_oe, "R7 field", odd_even_n_o, m_oe);
      // edge observations
      if (!csync_n_o && o_cs) cs_fall_cyc = cyc;
      if (!vsync_n_o && o_vs) begin
        vs_falls++;
        vs_fall_cyc = cyc;
        vs_on_rise = csync_n_o && !o_cs;
        def_dist = cyc - cs_fall_cyc;
      end
      if (vsync_n_o && !o_vs) vs_width = cyc - vs_fall_cyc;
      if (!bporch_n_o && o_bp) bp_fall_cyc = cyc;
      if (bporch_n_o && !o_bp) bp_width = cyc - bp_fall_cyc;
      o_cs = csync_n_o; o_vs = vsync_n_o; o_bp = bporch_n_o;
    end
  end

  task automatic drv(input bit v, input int n);
    csync_n_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lo_u, input int hi_u);
    drv(1'b0, lo_u*sc);
    drv(1'b1, hi_u*sc);
  endtask

  // kind: 0 odd with serrations, 1 even with serrations, 2 odd without serrations
  task automatic field(input int kind);
    int nl, w, start_falls;
    nl = 2 + int'($urandom_range(0, 3));
    repeat (nl) begin
      w = 4 + int'($urandom_range(0, 2));
      pulse(w, 63 - w + int'($urandom_range(0, 2)));
    end
    if (kind == 1) pulse(5, 27); else pulse(5, 59);
    repeat (6) pulse(2, 30);
    start_falls = vs_falls;
    if (kind != 2) repeat (6) pulse(27, 5);
    else begin drv(1'b0, 186*sc); drv(1'b1, 6*sc); end
    repeat (6) pulse(2, 30);
    repeat (4) pulse(5, 59);
    chk(vs_falls == start_falls + 1, "R2 one vertical strobe per field", vs_falls, start_falls + 1);
    if (kind != 2) chk(vs_on_rise, "R2 strobe on serration rise", vs_on_rise, 1);
    else chk(def_dist == DEF_U*sc, "R3 default delay", def_dist, DEF_U*sc);
    chk(vs_width == VS_U*sc, "R4 vertical width", vs_width, VS_U*sc);
    chk(bp_width == BP_U*sc, "R5 back porch width", bp_width, BP_U*sc);
    if (kind == 1) chk(odd_even_n_o == 1'b1, "R8 even field flag", odd_even_n_o, 1);
    else chk(odd_even_n_o == 1'b0, "R7 odd field flag", odd_even_n_o, 0);
  endtask

  initial begin
    int f0;
    void'($urandom(32'd4581));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(csync_n_o && vsync_n_o && bporch_n_o && odd_even_n_o, "R9 reset outputs",
        {csync_n_o, vsync_n_o, bporch_n_o, odd_even_n_o}, 15);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(csync_n_o && vsync_n_o && bporch_n_o && odd_even_n_o, "R9 idle after reset",
        {csync_n_o, vsync_n_o, bporch_n_o, odd_even_n_o}, 15);
    mon_en = 1'b1;
    // R6: lines and equalizers only
    f0 = vs_falls;
    repeat (10) pulse(5, 59);
    repeat (6) pulse(2, 30);
    repeat (3) pulse(5, 59);
    chk(vs_falls == f0, "R6 no strobe from short pulses", vs_falls, f0);
    // directed fields then random ones
    field(0);
    field(1);
    field(2);
    repeat (5) field(int'($urandom_range(0, 2)));
    // R6 boundary: one clock below the broad threshold
    drv(1'b1, 40*sc);
    f0 = vs_falls;
    drv(1'b0, BROAD_U*sc - 1);
    drv(1'b1, 40*sc);
    chk(vs_falls == f0, "R6 pulse one clock short of broad", vs_falls, f0);
    // R2 boundary: exactly at the broad threshold
    drv(1'b0, BROAD_U*sc);
    drv(1'b1, 300*sc);
    chk(vs_falls == f0 + 1, "R2 pulse exactly broad", vs_falls, f0 + 1);
    chk(vs_on_rise, "R2 strobe on rise at threshold", vs_on_rise, 1);
    chk(vs_width == VS_U*sc, "R4 width after boundary start", vs_width, VS_U*sc);
    // R10: retarget the scale while idle
    sc = 3;
    scale_i = 8'd3;
    drv(1'b1, 20*sc);
    field(1);
    chk(vs_width == VS_U*3, "R10 vertical width scales", vs_width, VS_U*3);
    chk(bp_width == BP_U*3, "R10 back porch width scales", bp_width, BP_U*3);
    field(2);
    chk(def_dist == DEF_U*3, "R10 default delay scales", def_dist, DEF_U*3);
    field(0);
    report();
  end
endmodule